// File: doc/BRIEF.md
# Gatable Astable / Monostable Multivibrator

This block is a clocked replacement for a resistor-capacitor multivibrator. A half-period count, given in system clock cycles on `half_cyc`, sets the timing that the external resistor and capacitor would otherwise set. A single counter core serves both modes of operation.

In free-running mode the block produces a square wave on `q`, with `q_n` as its complement. Free-running mode is enabled by either of two gate inputs, one active high and one active low. A raw oscillator tap, `osc`, runs at twice the `q` frequency. When neither gate is active, the block acts as a one-shot. A triggering edge fires a pulse one `q` period long, and a level-sensitive extend input keeps the pulse going for as long as it is held high.

An abort input ends any activity in the same cycle. If `q` drives an external N-counter that is cleared by the trigger, and the counter's "not done" output drives the active-low gate, the block produces a burst of exactly N periods.

Top module: `mvb_multivib`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first stimulus, `q`=0, `q_n`=1 and `osc`=0.
- R2: Free-running mode is active when `run_en`=1, or when `run_en_n`=0, or both. Either gate alone starts the oscillation.
- R3: In free-running mode with half-period H, `q` first rises on the third clock edge after the gate becomes active. It then toggles every H cycles, giving H cycles high and H cycles low. `q_n` is always the inverse of `q`.
- R4: While free-running with H>=2, `osc` toggles 4 times in every 2H cycles, which is twice per `q` half-period. With H=1, `osc` toggles on every cycle.
- R5: After the gate is removed, `q` is 0 from the third clock edge onward and stays low.
- R6: With no gate active, a rising edge on `fire_up` while `fire_dn`=0 makes `q` high from the third clock edge after the edge, for exactly 2H cycles. A rising edge on `fire_up` while `fire_dn`=1 fires nothing.
- R7: A falling edge on `fire_dn` while `fire_up`=1 fires the same 2H-cycle pulse with the same latency.
- R8: The pulse width does not depend on how long the trigger stays high. A new trigger edge arriving while a pulse is running is ignored.
- R9: If `extend` is held high for L cycles, the result is a single pulse with the same start latency and a width of 2H+L-1 cycles.
- R10: `kill`=1 forces `q`=0, `q_n`=1 and `osc`=0 in the same cycle and ends a running pulse, which does not resume. `kill` takes priority over any trigger or extend request that reaches the core during the same cycles.
- R11: `half_cyc`=0 is treated as H=1, so a one-shot pulse is 2 cycles wide.
- R12: When an external counter is cleared by the trigger, counts rising edges of `q`, and drives `run_en_n` low until it reaches N, `q` shows exactly N rising edges and then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| half_cyc | input | HALF_W | Half-period in clock cycles (0 is treated as 1) |
| fire_up | input | 1 | Rising-edge trigger, armed while `fire_dn` is low |
| fire_dn | input | 1 | Falling-edge trigger, armed while `fire_up` is high |
| run_en | input | 1 | Free-running gate, active high |
| run_en_n | input | 1 | Free-running gate, active low |
| extend | input | 1 | Level-sensitive retrigger |
| kill | input | 1 | Abort: clears output and state (synchronous to `clk`) |
| q | output | 1 | Main output |
| q_n | output | 1 | Complement of `q` |
| osc | output | 1 | Oscillator tap at twice the `q` frequency |

## Verification
Every input except `kill` passes through two synchronizer flops and is acted on at the next edge. A change driven just before edge E0 therefore shows at the outputs after edge E2. The bench drives on falling edges and samples at the following falling edges, so the third sample after a stimulus is the first one at which a result is due. `kill` masks the outputs combinationally, so it is sampled 1 ns after it is driven, within the same cycle. Pulse widths are counted as runs of high samples and compared with 2H or 2H+L-1. Free-running waveforms are compared sample by sample against the count from the third sample onward.

// File: rtl/mvb_pkg.sv
`timescale 1ns/1ps
package mvb_pkg;

  // Synchronized request inputs; field order fixes the bit order of the sync vector.
  typedef struct packed {
    logic up;
    logic dn;
    logic run;
    logic run_n;
    logic hold;
  } mvb_in_t;

  localparam int unsigned MVB_IN_W = $bits(mvb_in_t);

  // Reset value of each synchronizer bit: the active-low gate rests high.
  localparam logic [MVB_IN_W-1:0] MVB_SYNC_RST = 5'b00010;

  // Decoded requests presented to the counter core.
  typedef struct packed {
    logic gate;
    logic fire;
    logic hold;
  } mvb_ctl_t;

  // What the core does in a given cycle.
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_CLEAR,
    ACT_FREE,
    ACT_START,
    ACT_SHOT,
    ACT_END
  } mvb_act_e;

endpackage

// File: rtl/mvb_rst_sync.sv
`timescale 1ns/1ps
module mvb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mvb_sync.sv
`timescale 1ns/1ps
module mvb_sync #(
  parameter int              WIDTH   = 5,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] st_q;
    logic [STAGES-1:0] st_d;

    always_comb begin
      st_d = {st_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= {STAGES{RST_VAL[b]}};
      end else begin
        st_q <= st_d;
      end
    end

    assign dout[b] = st_q[STAGES-1];
  end

endmodule

// File: rtl/mvb_trig.sv
`timescale 1ns/1ps
module mvb_trig
  import mvb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mvb_in_t  sin,
  output mvb_ctl_t ctl
);

  logic up_prev_q, dn_prev_q;
  logic up_rise, dn_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev_q <= 1'b0;
      dn_prev_q <= 1'b0;
    end else begin
      up_prev_q <= sin.up;
      dn_prev_q <= sin.dn;
    end
  end

  always_comb begin
    up_rise  = sin.up & ~up_prev_q;
    dn_fall  = ~sin.dn & dn_prev_q;
    ctl.gate = sin.run | ~sin.run_n;
    // A trigger counts only while the opposite input holds its arming level.
    ctl.fire = ~ctl.gate & ((up_rise & ~sin.dn) | (dn_fall & sin.up));
    ctl.hold = ~ctl.gate & sin.hold;
  end

endmodule

// File: rtl/mvb_core.sv
`timescale 1ns/1ps
module mvb_core
  import mvb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_cyc,
  input  mvb_ctl_t          ctl,
  input  logic              kill,
  output logic              q_o,
  output logic              osc_o
);

  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] half_eff, hm1, lo_m1;
  logic              has_mid, wrap, mid, at_rest, st_en;
  logic [HALF_W-1:0] cnt_q, cnt_d, step_cnt;
  logic              ph_q, ph_d, step_ph;
  logic              osc_q, osc_d, step_osc;
  logic              mono_q, mono_d;
  logic              q_q, q_d;
  mvb_act_e          act;

  // Timing decode
  always_comb begin
    half_eff = (half_cyc == '0) ? ONE : half_cyc;
    hm1      = half_eff - ONE;
    lo_m1    = (half_eff >> 1) - ONE;
    has_mid  = (half_eff > ONE);
    wrap     = (cnt_q >= hm1);
    mid      = has_mid && (cnt_q == lo_m1);
    at_rest  = !mono_q && !q_q && !osc_q && !ph_q && (cnt_q == hm1);
  end

  // One counting step shared by free-running and one-shot operation
  always_comb begin
    if (wrap) begin
      step_cnt = '0;
      step_ph  = ~ph_q;
      step_osc = ~osc_q;
    end else begin
      step_cnt = cnt_q + ONE;
      step_ph  = ph_q;
      step_osc = mid ? ~osc_q : osc_q;
    end
  end

  // Action select: abort, then gate, then start/extend, then running shot
  always_comb begin
    if (kill) begin
      act = ACT_CLEAR;
    end else if (ctl.gate) begin
      act = ACT_FREE;
    end else if (ctl.hold || (ctl.fire && !mono_q)) begin
      act = ACT_START;
    end else if (mono_q) begin
      act = (wrap && !ph_q) ? ACT_END : ACT_SHOT;
    end else begin
      act = ACT_IDLE;
    end
  end

  // Next state
  always_comb begin
    cnt_d  = hm1;
    ph_d   = 1'b0;
    osc_d  = 1'b0;
    mono_d = 1'b0;
    q_d    = 1'b0;
    case (act)
      ACT_FREE: begin
        cnt_d = step_cnt;
        ph_d  = step_ph;
        osc_d = step_osc;
        q_d   = step_ph;
      end
      ACT_START: begin
        cnt_d  = '0;
        ph_d   = 1'b1;
        osc_d  = 1'b1;
        mono_d = 1'b1;
        q_d    = 1'b1;
      end
      ACT_SHOT: begin
        cnt_d  = step_cnt;
        ph_d   = step_ph;
        osc_d  = step_osc;
        mono_d = 1'b1;
        q_d    = 1'b1;
      end
      default: ;
    endcase
    st_en = !((act == ACT_IDLE || act == ACT_CLEAR || act == ACT_END) && at_rest);
  end

  // State registers with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      osc_q  <= 1'b0;
      mono_q <= 1'b0;
      q_q    <= 1'b0;
    end else if (st_en) begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      osc_q  <= osc_d;
      mono_q <= mono_d;
      q_q    <= q_d;
    end
  end

  assign q_o   = q_q;
  assign osc_o = osc_q;

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!q_q && !mono_q && !osc_q)); // R10

  AST_GATE_NO_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.gate && !kill) |=> !mono_q); // R2

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl.hold || (ctl.fire && !mono_q)) && !ctl.gate && !kill) |=> (q_q && mono_q && cnt_q == '0)); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.gate && !mono_q && !ctl.fire && !ctl.hold) |=> !q_q); // R5

  AST_HALF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.gate && !kill && !wrap && !mono_q) |=> $stable(q_q)); // R3

endmodule

// File: rtl/mvb_multivib.sv
`timescale 1ns/1ps
module mvb_multivib
  import mvb_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_cyc,
  input  logic              fire_up,
  input  logic              fire_dn,
  input  logic              run_en,
  input  logic              run_en_n,
  input  logic              extend,
  input  logic              kill,
  output logic              q,
  output logic              q_n,
  output logic              osc
);

  logic                rst_sync_n;
  logic [MVB_IN_W-1:0] raw_vec, sync_vec;
  mvb_in_t             sin;
  mvb_ctl_t            ctl;
  logic                q_core, osc_core;

  mvb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_vec = {fire_up, fire_dn, run_en, run_en_n, extend};

  mvb_sync #(
    .WIDTH   (MVB_IN_W),
    .STAGES  (SYNC_STG),
    .RST_VAL (MVB_SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (raw_vec),
    .dout  (sync_vec)
  );

  assign sin = mvb_in_t'(sync_vec);

  mvb_trig u_trig (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .sin   (sin),
    .ctl   (ctl)
  );

  mvb_core #(.HALF_W(HALF_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .half_cyc (half_cyc),
    .ctl      (ctl),
    .kill     (kill),
    .q_o      (q_core),
    .osc_o    (osc_core)
  );

  // Abort masks the outputs in the same cycle; state clears on the next edge.
  assign q   = q_core & ~kill;
  assign q_n = ~q;
  assign osc = osc_core & ~kill;

endmodule

// File: tb/test_mvb_multivib.sv
`timescale 1ns/1ps
module test_mvb_multivib;

  localparam int HW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [HW-1:0] half_cyc;
  logic          fire_up, fire_dn, run_en, run_en_n, extend, kill;
  logic          q, q_n, osc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mvb_multivib #(.HALF_W(HW)) i_mvb_multivib (
    .clk(clk), .rst_n(rst_n), .half_cyc(half_cyc),
    .fire_up(fire_up), .fire_dn(fire_dn), .run_en(run_en), .run_en_n(run_en_n),
    .extend(extend), .kill(kill), .q(q), .q_n(q_n), .osc(osc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff_h(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  function automatic bit exp_free_q(input int k, input int h);
    if (k < 3) return 1'b0;
    return (((k - 3) / h) % 2) == 0;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One-shot: mode 0 rising fire_up, 1 falling fire_dn, 2 extend held d cycles
  task automatic shot(input int hraw, input int mode, input int d, input bit again, input string tag);
    int h = eff_h(hraw);
    int first = -1;
    int width = 0;
    int bad_c = 0;
    int exp_w = (mode == 2) ? (2 * h + d - 1) : (2 * h);
    half_cyc = HW'(hraw);
    case (mode)
      0: fire_up = 1'b1;
      1: fire_dn = 1'b0;
      default: extend = 1'b1;
    endcase
    for (int k = 1; k <= 2 * h + d + 8; k++) begin
      @(negedge clk);
      if (q) begin
        width++;
        if (first < 0) first = k;
      end
      if (q_n !== ~q) bad_c++;
      if (mode == 0 && k == d) fire_up = 1'b0;
      if (mode == 0 && again && k == d + 1) fire_up = 1'b1;
      if (mode == 0 && again && k == d + 2) fire_up = 1'b0;
      if (mode == 1 && k == d) fire_dn = 1'b1;
      if (mode == 2 && k == d) extend = 1'b0;
    end
    chk(first == 3, {tag, " start"}, first, 3);
    chk(width == exp_w, {tag, " width"}, width, exp_w);
    chk(bad_c == 0, "R3 q_n complement", bad_c, 0);
  endtask

  // Free-running with either gate polarity
  task automatic free_run(input int h, input bit use_n);
    int bad_q = 0;
    int tog = 0;
    int exp_t = (h >= 2) ? 8 : 4;
    int late_hi = 0;
    logic prev_osc;
    half_cyc = HW'(h);
    if (use_n) run_en_n = 1'b0; else run_en = 1'b1;
    for (int k = 1; k <= 3 + 4 * h; k++) begin
      @(negedge clk);
      if (q !== exp_free_q(k, h) || q_n !== ~q) bad_q++;
      if (k > 3 && osc !== prev_osc) tog++;
      prev_osc = osc;
    end
    chk(bad_q == 0, use_n ? "R2 gate low-active / R3 wave" : "R2 gate high-active / R3 wave", bad_q, 0);
    chk(tog == exp_t, "R4 osc toggles per two periods", tog, exp_t);
    run_en = 1'b0;
    run_en_n = 1'b1;
    for (int k = 1; k <= 2 * h + 3; k++) begin
      @(negedge clk);
      if (k >= 3 && q) late_hi++;
    end
    chk(late_hi == 0, "R5 low after gate removed", late_hi, 0);
  endtask

  task automatic kill_test(input int h, input int kk);
    int hi_after = 0;
    half_cyc = HW'(h);
    fire_up = 1'b1;
    for (int k = 1; k <= kk; k++) begin
      @(negedge clk);
      if (k == 1) fire_up = 1'b0;
    end
    chk(q == 1'b1, "R10 pulse running before abort", q, 1);
    kill = 1'b1;
    extend = 1'b1;
    #1;
    chk(q == 1'b0 && q_n == 1'b1 && osc == 1'b0, "R10 same-cycle abort", {q, q_n, osc}, 3'b010);
    for (int k = 1; k <= 2 * h + 8; k++) begin
      @(negedge clk);
      if (q) hi_after++;
      if (k == 1) extend = 1'b0;
      if (k == 4) kill = 1'b0;
    end
    chk(hi_after == 0, "R10 no resume, abort beats extend", hi_after, 0);
  endtask

  task automatic countdown(input int h, input int n);
    int cnt = 0;
    int rises = 0;
    logic pq = 1'b0;
    half_cyc = HW'(h);
    run_en_n = 1'b0;
    fire_up = 1'b1;
    for (int k = 1; k <= 2 * h * n + 2 * h + 10; k++) begin
      @(negedge clk);
      if (k == 1) fire_up = 1'b0;
      if (q && !pq) begin
        rises++;
        cnt++;
      end
      pq = q;
      if (cnt >= n) run_en_n = 1'b1;
    end
    chk(rises == n, "R12 burst length", rises, n);
    chk(q == 1'b0, "R12 ends low", q, 0);
  endtask

  initial begin
    int quiet;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    half_cyc = HW'(3);
    fire_up = 1'b0; fire_dn = 1'b0; run_en = 1'b0; run_en_n = 1'b1;
    extend = 1'b0; kill = 1'b0;
    idle(3);
    chk(q == 1'b0 && q_n == 1'b1 && osc == 1'b0, "R1 in reset", {q, q_n, osc}, 3'b010);
    rst_n = 1'b1;
    idle(6);
    chk(q == 1'b0 && q_n == 1'b1 && osc == 1'b0, "R1 after release", {q, q_n, osc}, 3'b010);

    // Directed cases
    shot(3, 0, 1, 1'b0, "R6 rise short");
    idle(4);
    shot(3, 0, 12, 1'b0, "R8 rise long");
    idle(4);
    shot(4, 0, 2, 1'b1, "R8 edge during pulse");
    idle(4);
    shot(0, 0, 1, 1'b0, "R11 zero half");
    idle(4);
    shot(2, 2, 5, 1'b0, "R9 extend level");
    idle(4);
    // Armed by fire_dn high: fire_up rise must not fire
    fire_dn = 1'b1;
    idle(4);
    fire_up = 1'b1;
    quiet = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (q) quiet++;
    end
    chk(quiet == 0, "R6 rise blocked by fire_dn", quiet, 0);
    shot(3, 1, 2, 1'b0, "R7 fall trigger");
    fire_up = 1'b0;
    idle(3);
    fire_dn = 1'b0;
    idle(4);
    free_run(3, 1'b0);
    idle(4);
    free_run(1, 1'b1);
    idle(4);
    kill_test(4, 5);
    idle(4);
    countdown(5, 3);
    idle(6);

    // Random mix
    for (int it = 0; it < 24; it++) begin
      int h = $urandom_range(6, 1);
      int m = $urandom_range(4, 0);
      case (m)
        0: begin
          int d = $urandom_range(3 * h + 2, 1);
          bit ag = (d + 1 <= 2 * h - 1) ? bit'($urandom_range(1, 0)) : 1'b0;
          shot(h, 0, d, ag, "R6 R8 random rise");
        end
        1: begin
          fire_dn = 1'b1;
          idle(4);
          fire_up = 1'b1;
          idle(4);
          shot(h, 1, $urandom_range(2 * h + 2, 1), 1'b0, "R7 random fall");
          fire_up = 1'b0;
          idle(3);
          fire_dn = 1'b0;
        end
        2: shot(h, 2, $urandom_range(2 * h + 2, 1), 1'b0, "R9 random extend");
        3: free_run(h, bit'($urandom_range(1, 0)));
        default: kill_test(h, $urandom_range(2 * h + 2, 3));
      endcase
      idle(5);
    end
    countdown(4, 2);
    countdown(6, 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule